// File: doc/BRIEF.md
# Delay-Code Programming Interface

This block owns the 8-bit code that sets a programmable delay element. Code 0 selects the shortest delay and code 255 the longest, in equal steps. The code can be loaded in three ways. In transparent parallel loading, the code follows the parallel pins while the enable is high. In latched parallel loading, the parallel pins are captured when the enable falls. In serial loading, bits shift in on a serial clock, MSB first, and the shifted value takes effect only when the enable falls.

The serial path shifts in a way that allows several blocks to be chained. The serial output always shows the MSB of an internal input register. Each serial clock rising edge pushes the previous contents out, one bit at a time, so a read always destroys the old value. To keep the old value, the host writes back the bits it reads before the enable falls.

The enable and the serial clock arrive asynchronously. The block samples them on a faster system clock through a synchronizer, and samples the other pins through the same synchronizer so that all pins stay aligned. The mode pin is captured when the enable rises, which fixes the mode of each enable-high session.

Top module: `dly_code_prog`

## Requirements
- R1: A synchronous reset clears the active code and the input register to 0 and drives the serial output enable low.
- R2: In a session opened with the mode pin at 1, while the enable stays high and the mode pin stays at 1, the active code takes the parallel pin value. The parallel pins map bit for bit: pin bit 7 is the code MSB and pin bit 0 is the code LSB. Any pin change reaches the outputs SYNC_STAGES+1 system clocks later.
- R3: When the enable falls and the session was opened with the mode pin at 1, the active code takes the parallel value. Later parallel changes while the enable is low have no effect.
- R4: In a session opened with the mode pin at 0, each rising serial clock edge while the enable is high shifts the serial input into bit 0 and moves every other bit up one place. After eight edges, the first bit sent sits in bit 7.
- R5: In a serial session, the active code does not change while the enable is high. When the enable falls, the active code takes the input register value.
- R6: During a serial session, the serial output shows bit 7 of the input register. This holds as soon as the session opens, before any serial clock edge.
- R7: Eight serial edges move all old register bits out through the serial output, MSB first, so the read is destructive. Shifting the bits that were read back in leaves the code unchanged.
- R8: The serial output enable is high only while the enable is high in a serial session. It is low when the enable is low and throughout parallel sessions.
- R9: Serial clock edges have no effect on the input register while the enable is low or during a parallel session.
- R10: The session mode is fixed when the enable rises. If the mode pin leaves 1 during a parallel session, the code freezes until the enable falls. Each commit follows the mode that was captured when the session opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_par | input | 1 | Mode pin: 1 = parallel loading, 0 = serial loading |
| addr_en | input | 1 | Enable pin, asynchronous |
| par_code | input | CODE_W | Parallel code pins, bit CODE_W-1 is the MSB |
| sclk | input | 1 | Serial clock, asynchronous |
| sdata_in | input | 1 | Serial data input |
| sdata_out | output | 1 | Serial data output (MSB of the input register) |
| sdata_oe | output | 1 | Output enable for the serial output; low means high impedance |
| code_out | output | CODE_W | Active delay code |

## Verification
Two events can land in the same synchronized cycle: a serial clock rising edge and an enable falling edge. This case matters most. The bench provokes it by driving both pins on the same statement after seven bits of a transfer. Because both pins pass through the same synchronizer, they are seen together. The correct outcome is that the edge is dropped, and the committed code is the register value after seven shifts. The behavioural model in the bench predicts this outcome on every clock, and a directed check on the expected constant judges it.

// File: rtl/dcp_pkg.sv
package dcp_pkg;
  typedef enum logic {
    SES_SERIAL   = 1'b0,
    SES_PARALLEL = 1'b1
  } ses_mode_t;
endpackage

// File: rtl/dcp_sync.sv
module dcp_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[i] <= '0;
          else     stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign dout = stg[STAGES-1];
endmodule

// File: rtl/dcp_edge.sv
module dcp_edge #(
  parameter bit RISING = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic pulse
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= lvl;
  end

  generate
    if (RISING) begin : g_rise
      assign pulse = lvl & ~prev_q;
    end else begin : g_fall
      assign pulse = ~lvl & prev_q;
    end
  endgenerate
endmodule

// File: rtl/dcp_shreg.sv
module dcp_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         din,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[W-2:0], din};
  end

  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q)); // R9
  AST_SHIFT_LSB_IN: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> (q[0] == $past(din) && q[W-1:1] == $past(q[W-2:0]))); // R4
endmodule

// File: rtl/dly_code_prog.sv
module dly_code_prog #(
  parameter int CODE_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_par,
  input  logic              addr_en,
  input  logic [CODE_W-1:0] par_code,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic [CODE_W-1:0] code_out
);
  import dcp_pkg::*;

  localparam int BUS_W  = CODE_W + 4;
  localparam int B_MD   = CODE_W + 3;
  localparam int B_AE   = CODE_W + 2;
  localparam int B_SC   = CODE_W + 1;
  localparam int B_SI   = CODE_W;

  logic [BUS_W-1:0]  bus_raw, bus_s;
  logic              md_s, ae_s, sc_s, si_s;
  logic [CODE_W-1:0] par_s;
  logic              ae_rise, ae_fall, sc_rise;
  ses_mode_t         ses_q, ses_eff;
  logic              shift_en;
  logic [CODE_W-1:0] sreg;
  logic [CODE_W-1:0] code_q;
  logic              oe_q;

  assign bus_raw = {mode_par, addr_en, sclk, sdata_in, par_code};

  dcp_sync #(.W(BUS_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst (rst), .din (bus_raw), .dout (bus_s)
  );

  assign md_s  = bus_s[B_MD];
  assign ae_s  = bus_s[B_AE];
  assign sc_s  = bus_s[B_SC];
  assign si_s  = bus_s[B_SI];
  assign par_s = bus_s[CODE_W-1:0];

  dcp_edge #(.RISING(1'b1)) u_ae_rise (.clk(clk), .rst(rst), .lvl(ae_s), .pulse(ae_rise));
  dcp_edge #(.RISING(1'b0)) u_ae_fall (.clk(clk), .rst(rst), .lvl(ae_s), .pulse(ae_fall));
  dcp_edge #(.RISING(1'b1)) u_sc_rise (.clk(clk), .rst(rst), .lvl(sc_s), .pulse(sc_rise));

  // session mode is taken when the enable rises
  assign ses_eff = ae_rise ? ses_mode_t'(md_s) : ses_q;

  always_ff @(posedge clk) begin
    if (rst)          ses_q <= SES_SERIAL;
    else if (ae_rise) ses_q <= ses_mode_t'(md_s);
  end

  assign shift_en = ae_s & (ses_eff == SES_SERIAL) & sc_rise;

  dcp_shreg #(.W(CODE_W)) u_shreg (
    .clk (clk), .rst (rst), .shift_en (shift_en), .din (si_s), .q (sreg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
    end else if (ae_fall) begin
      code_q <= (ses_q == SES_PARALLEL) ? par_s : sreg;
    end else if (ae_s && ses_eff == SES_PARALLEL && md_s) begin
      code_q <= par_s;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) oe_q <= 1'b0;
    else     oe_q <= ae_s & (ses_eff == SES_SERIAL);
  end

  assign code_out  = code_q;
  assign sdata_oe  = oe_q;
  assign sdata_out = sreg[CODE_W-1];

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (code_out == '0 && !sdata_oe)); // R1
  AST_PAR_COMMIT: assert property (@(posedge clk) disable iff (rst)
    (ae_fall && ses_q == SES_PARALLEL) |=> (code_out == $past(par_s))); // R3
  AST_SERIAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (ae_s && !ae_rise && ses_q == SES_SERIAL) |=> $stable(code_out)); // R5
  AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
    !ae_s |=> !sdata_oe); // R8
  AST_MODE_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (ae_s && !ae_rise && ses_q == SES_PARALLEL && !md_s) |=> $stable(code_out)); // R10
endmodule

// File: tb/dly_code_prog_test.sv
`timescale 1ns/1ps
module dly_code_prog_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       md = 1'b0, ae = 1'b0, sc = 1'b0, si = 1'b0;
  logic [7:0] par = 8'h00;
  logic       so, oe;
  logic [7:0] code;

  int tests = 0, fails = 0, cycles = 0;
  string tag = "R1";
  bit started = 0;

  always #2 clk = ~clk;

  dly_code_prog uut (
    .clk(clk), .rst(rst), .mode_par(md), .addr_en(ae), .par_code(par),
    .sclk(sc), .sdata_in(si), .sdata_out(so), .sdata_oe(oe), .code_out(code)
  );

  // behavioural reference: pins seen two clocks late, edges from consecutive samples
  logic [11:0] hist[$] = '{12'h0, 12'h0, 12'h0, 12'h0};
  logic [7:0]  m_code = 0, m_sreg = 0;
  logic        m_oe = 0, m_ses = 0;

  always @(posedge clk) begin
    logic [11:0] c, p;
    logic ar, af, sr, se;
    hist.push_front(rst ? 12'h0 : {md, ae, sc, si, par});
    void'(hist.pop_back());
    c = hist[2]; p = hist[3];
    if (rst) begin
      m_code = 0; m_sreg = 0; m_oe = 0; m_ses = 0;
    end else begin
      ar = c[10] && !p[10];
      af = !c[10] && p[10];
      sr = c[9] && !p[9];
      se = ar ? c[11] : m_ses;
      if (af) m_code = m_ses ? c[7:0] : m_sreg;
      else if (c[10] && se && c[11]) m_code = c[7:0];
      m_oe = c[10] && !se;
      if (c[10] && !se && sr) m_sreg = {m_sreg[6:0], c[8]};
      if (ar) m_ses = c[11];
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !rst) begin
      tests++;
      if (code !== m_code || oe !== m_oe || (m_oe && so !== m_sreg[7])) begin
        fails++;
        $display("FAIL %s model: code=%h oe=%b so=%b expected code=%h oe=%b so=%b",
                 tag, code, oe, so, m_code, m_oe, m_sreg[7]);
      end
    end
  end

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: cycles=%0d expected below 100000", cycles);
      finish_run();
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bit(input logic b, output logic seen);
    seen = so;
    si = b; wait_clk(2);
    sc = 1'b1; wait_clk(4);
    sc = 1'b0; wait_clk(4);
  endtask

  task automatic ser_xfer(input logic [7:0] wr, output logic [7:0] rd);
    for (int i = 7; i >= 0; i--) shift_bit(wr[i], rd[i]);
  endtask

  initial begin
    logic [7:0] rd;
    logic       dummy;
    wait_clk(6);
    chk(code, 8'h00, "R1 code after reset");
    chk({7'b0, oe}, 8'h00, "R1 oe after reset");
    rst = 1'b0; wait_clk(2);

    // transparent parallel
    tag = "R2"; md = 1; par = 8'h3C; ae = 1; wait_clk(5);
    chk(code, 8'h3C, "R2 transparent");
    chk({7'b0, oe}, 8'h00, "R8 oe low in parallel");
    par = 8'hC3; wait_clk(5);
    chk(code, 8'hC3, "R2 transparent follow");
    tag = "R3"; ae = 0; wait_clk(5);
    par = 8'h11; wait_clk(5);
    chk(code, 8'hC3, "R3 pins ignored while enable low");

    // latched parallel pulse
    par = 8'hA5; wait_clk(2); ae = 1; wait_clk(4); ae = 0; wait_clk(5);
    par = 8'h5A; wait_clk(5);
    chk(code, 8'hA5, "R3 latched on fall");

    // serial write
    tag = "R4"; md = 0; ae = 1; wait_clk(5);
    chk({7'b0, oe}, 8'h01, "R8 oe high in serial");
    chk({7'b0, so}, 8'h00, "R6 old msb before clock");
    ser_xfer(8'h96, rd);
    chk(code, 8'hA5, "R5 hold while enable high");
    tag = "R5"; ae = 0; wait_clk(5);
    chk(code, 8'h96, "R5 commit on fall");
    chk({7'b0, oe}, 8'h00, "R8 oe low after fall");

    // destructive read
    tag = "R7"; ae = 1; wait_clk(5);
    chk({7'b0, so}, 8'h01, "R6 msb visible on open");
    ser_xfer(8'h0F, rd);
    chk(rd, 8'h96, "R7 read bits");
    ae = 0; wait_clk(5);
    chk(code, 8'h0F, "R7 destructive read replaced code");
    ae = 1; wait_clk(5);
    ser_xfer(8'h0F, rd);
    chk(rd, 8'h0F, "R7 read before write-back");
    ae = 0; wait_clk(5);
    chk(code, 8'h0F, "R7 write-back keeps code");

    // serial clock ignored
    tag = "R9";
    for (int k = 0; k < 8; k++) shift_bit(1'b1, dummy);
    md = 1; par = 8'h0F; ae = 1; wait_clk(5);
    for (int k = 0; k < 8; k++) shift_bit(1'b1, dummy);
    ae = 0; wait_clk(5);
    md = 0; ae = 1; wait_clk(5);
    ser_xfer(8'h0F, rd);
    chk(rd, 8'h0F, "R9 register untouched by ignored edges");
    ae = 0; wait_clk(5);

    // mode change mid-session
    tag = "R10"; md = 1; par = 8'h77; ae = 1; wait_clk(5);
    chk(code, 8'h77, "R2 transparent second session");
    md = 0; par = 8'h88; wait_clk(5);
    chk(code, 8'h77, "R10 frozen after mode change");
    chk({7'b0, oe}, 8'h00, "R8 oe stays low in parallel session");
    ae = 0; wait_clk(5);
    chk(code, 8'h88, "R10 parallel commit per session");
    ae = 1; wait_clk(5);
    ser_xfer(8'h21, rd);
    chk(rd, 8'h0F, "R9 parallel session left register intact");
    md = 1; par = 8'hEE; wait_clk(5);
    chk(code, 8'h88, "R10 serial session ignores pins");
    ae = 0; wait_clk(5);
    chk(code, 8'h21, "R10 serial commit per session");

    // serial edge coinciding with enable fall
    tag = "R5"; md = 0; wait_clk(2); ae = 1; wait_clk(5);
    for (int i = 6; i >= 0; i--) shift_bit(7'b0101010 >> i, dummy);
    si = 1'b1; wait_clk(2);
    sc = 1'b1; ae = 1'b0; wait_clk(6);
    sc = 1'b0; wait_clk(5);
    chk(code, 8'hAA, "R4 R5 edge at fall dropped");

    wait_clk(4);
    finish_run();
  end
endmodule